// File: doc/BRIEF.md
# Circular Trace Capture Buffer

The block stores a stream of fixed-width trace words into an on-chip ring of RAM entries while capture is on. A host programs it over a simple register bus: it loads a post-trigger word count, zeroes the write pointer, and sets the enable bit. Words are stored one per entry. In paired mode, two successive words are packed into one entry, with the first word in the low half. When a trigger pulse arrives, the block keeps storing for the programmed number of entries and then stops. As a result, the stored window can sit mostly before or mostly after the event.

Four status flags let the host rebuild the stored history. The flags are: write pointer has wrapped, trigger seen, acquisition finished, and no half-packed word pending. When the wrap flag is set, the oldest entry sits at the write pointer. When it is clear, the valid entries run from 0 up to the write pointer minus one. The host points the read pointer at the first entry it wants. It then reads the data register repeatedly, and each read advances the read pointer by one.

Register map (3-bit address): 0 depth (RO), 1 entry width (RO), 2 status, 3 RAM data, 4 read pointer, 5 write pointer, 6 post-trigger count, 7 control.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset the status register and status_o read 4'b1000 (only bit 3 set), and control, read pointer and write pointer read 0.
- R2: Control bit 0 enables capture; trace words presented while it is 0 are not stored and the write pointer does not move.
- R3: With control bit 1 clear, each valid trace word is stored at the write pointer as an entry whose low TW_W bits hold the word and whose upper bits are zero, and the write pointer then advances by one, wrapping at DEPTH.
- R4: With control bit 1 set, two consecutive valid words form one entry {second, first}; while one word waits for its partner, status bit 3 (formatter empty) reads 0.
- R5: Status bit 0 (full) sets when an entry is stored at address DEPTH-1, so the write pointer wraps to 0; the oldest entry is then at the write pointer.
- R6: A trigger pulse during capture sets status bit 1 on the next clock; after the trigger cycle exactly N further entries are stored, where N is the post-trigger count register, and then status bit 2 (acquisition complete) sets and nothing more is stored.
- R7: A trigger pulse while status bit 1 is already set is ignored and does not restart the post-trigger count.
- R8: A half-packed word still waiting when capture is turned off or acquisition completes is written as its own entry with zero upper half, after which status bit 3 reads 1.
- R9: Writing the write pointer register loads it and clears status bits 0, 1 and 2 and any waiting half-packed word.
- R10: Reading the data register returns the entry at the read pointer and then increments the read pointer; the read pointer is also host-writable.
- R11: The depth register reads DEPTH and the width register reads the entry width 2*TW_W; writes to them have no effect.
- R12: Register read data appears on reg_rdata_o in the clock cycle after the cycle in which reg_rd_i is high, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tr_valid_i | input | 1 | Trace word valid strobe |
| tr_data_i | input | TW_W | Trace word |
| trig_i | input | 1 | Trigger pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Registered read data |
| status_o | output | 4 | {formatter empty, acq complete, triggered, full} |

## Verification
A register write lands on the clock edge after the strobe is set. Register read data is due one edge after the read strobe. The bench models this by pushing the expected value into a queue when it drives a read. A monitor pops the queue on the falling edge that follows the latching edge.

Status flags are sampled on a falling edge. For the trigger, status bit 1 is checked low on the falling edge where the pulse is driven and high on the next one. For paired-mode shutdown, the flush entry is stored one edge after the control write takes effect, and the checks wait for that edge before sampling.

Capture outcomes are judged only through pointers and stored entries read back over the bus. These include stop after N entries, ignored re-triggers and the wrap position.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_DEPTH = 3'd0;
  localparam logic [ADDR_W-1:0] A_WIDTH = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd3;
  localparam logic [ADDR_W-1:0] A_RPTR  = 3'd4;
  localparam logic [ADDR_W-1:0] A_WPTR  = 3'd5;
  localparam logic [ADDR_W-1:0] A_TCNT  = 3'd6;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd7;

  // bit 3..0: host decodes these positions
  typedef struct packed {
    logic fmt_empty;
    logic acq_done;
    logic triggered;
    logic full;
  } tcb_status_t;
endpackage

// File: rtl/tcb_ram.sv
module tcb_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tcb_packer.sv
module tcb_packer #(
  parameter int TW_W = 8,
  localparam int EW = 2 * TW_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            gate_i,
  input  logic            valid_i,
  input  logic [TW_W-1:0] data_i,
  input  logic            demux_i,
  input  logic            flush_i,
  output logic            wr_o,
  output logic [EW-1:0]   wdata_o,
  output logic            empty_o
);
  logic            pend_q;
  logic [TW_W-1:0] hold_q;
  logic            take;

  assign take = gate_i && valid_i;

  always_comb begin
    wr_o    = 1'b0;
    wdata_o = '0;
    if (!clr_i) begin
      if (take) begin
        if (!demux_i) begin
          wr_o    = 1'b1;
          wdata_o = {{TW_W{1'b0}}, data_i};
        end else if (pend_q) begin
          wr_o    = 1'b1;
          wdata_o = {data_i, hold_q};
        end
      end else if (flush_i && pend_q) begin
        wr_o    = 1'b1;
        wdata_o = {{TW_W{1'b0}}, hold_q};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      hold_q <= '0;
    end else if (clr_i) begin
      pend_q <= 1'b0;
    end else if (take && demux_i) begin
      if (!pend_q) begin
        hold_q <= data_i;
        pend_q <= 1'b1;
      end else begin
        pend_q <= 1'b0;
      end
    end else if (flush_i && pend_q) begin
      pend_q <= 1'b0;
    end
  end

  assign empty_o = !pend_q;

  // R8
  flush_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && !take) |-> !empty_o);

  // R4
  pair_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && demux_i && !clr_i) |=> (empty_o != $past(empty_o)));
endmodule

// File: rtl/tcb_acq.sv
module tcb_acq #(
  parameter int DEPTH = 16,
  parameter int REG_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             trig_i,
  input  logic             commit_i,
  input  logic             host_wp_we_i,
  input  logic [AW-1:0]    host_wp_i,
  input  logic [REG_W-1:0] tcnt_i,
  output logic             gate_o,
  output logic             flush_o,
  output logic [AW-1:0]    wptr_o,
  output logic             full_o,
  output logic             trig_o,
  output logic             done_o
);
  logic [AW-1:0]    wptr_q;
  logic [REG_W-1:0] remain_q;
  logic             full_q, trig_q, done_q;
  logic             stop;

  assign stop    = trig_q && (remain_q == '0);
  assign gate_o  = en_i && !done_q && !stop;
  assign flush_o = !en_i || done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q   <= '0;
      remain_q <= '0;
      full_q   <= 1'b0;
      trig_q   <= 1'b0;
      done_q   <= 1'b0;
    end else if (host_wp_we_i) begin
      wptr_q   <= host_wp_i;
      remain_q <= '0;
      full_q   <= 1'b0;
      trig_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (commit_i) begin
        wptr_q <= wptr_q + 1'b1;
        if (wptr_q == AW'(DEPTH - 1)) full_q <= 1'b1;
        if (trig_q && remain_q != '0) remain_q <= remain_q - 1'b1;
      end
      // later triggers ignored once one has been taken
      if (trig_i && en_i && !trig_q && !done_q) begin
        trig_q   <= 1'b1;
        remain_q <= tcnt_i;
      end
      if (stop) done_q <= 1'b1;
    end
  end

  assign wptr_o = wptr_q;
  assign full_o = full_q;
  assign trig_o = trig_q;
  assign done_o = done_q;

  // R3
  wptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !host_wp_we_i) |=> (wptr_q == $past(wptr_q) + 1'b1));

  // R5
  full_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> $past(commit_i && wptr_q == AW'(DEPTH - 1)));

  // R6
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !host_wp_we_i) |=> done_q);

  // R7
  retrig_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && trig_i && !commit_i && !host_wp_we_i) |=> (remain_q == $past(remain_q)));

  // R9
  host_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wp_we_i |=> (!full_q && !trig_q && !done_q));
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import tcb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TW_W  = 8,
  parameter int REG_W = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int EW   = 2 * TW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tr_valid_i,
  input  logic [TW_W-1:0]   tr_data_i,
  input  logic              trig_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic [3:0]        status_o
);
  logic [1:0]       ctrl_q;
  logic [REG_W-1:0] tcnt_q;
  logic [AW-1:0]    rptr_q, wptr;
  logic [REG_W-1:0] rdata_q, rd_val;
  logic [EW-1:0]    ram_wdata, ram_rdata;
  logic             commit, gate, flush, full, trig, done, empty;
  logic             wp_we, data_rd;
  tcb_status_t      stat;

  assign wp_we   = reg_wr_i && (reg_addr_i == A_WPTR);
  assign data_rd = reg_rd_i && (reg_addr_i == A_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      tcnt_q <= '0;
      rptr_q <= '0;
    end else begin
      if (reg_wr_i && reg_addr_i == A_CTRL) ctrl_q <= reg_wdata_i[1:0];
      if (reg_wr_i && reg_addr_i == A_TCNT) tcnt_q <= reg_wdata_i;
      if (reg_wr_i && reg_addr_i == A_RPTR) rptr_q <= reg_wdata_i[AW-1:0];
      else if (data_rd)                     rptr_q <= rptr_q + 1'b1;
    end
  end

  tcb_acq #(.DEPTH(DEPTH), .REG_W(REG_W)) u_acq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (ctrl_q[0]),
    .trig_i       (trig_i),
    .commit_i     (commit),
    .host_wp_we_i (wp_we),
    .host_wp_i    (reg_wdata_i[AW-1:0]),
    .tcnt_i       (tcnt_q),
    .gate_o       (gate),
    .flush_o      (flush),
    .wptr_o       (wptr),
    .full_o       (full),
    .trig_o       (trig),
    .done_o       (done)
  );

  tcb_packer #(.TW_W(TW_W)) u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (wp_we),
    .gate_i  (gate),
    .valid_i (tr_valid_i),
    .data_i  (tr_data_i),
    .demux_i (ctrl_q[1]),
    .flush_i (flush),
    .wr_o    (commit),
    .wdata_o (ram_wdata),
    .empty_o (empty)
  );

  tcb_ram #(.DEPTH(DEPTH), .WIDTH(EW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (commit),
    .waddr_i (wptr),
    .wdata_i (ram_wdata),
    .raddr_i (rptr_q),
    .rdata_o (ram_rdata)
  );

  assign stat = '{fmt_empty: empty, acq_done: done, triggered: trig, full: full};

  always_comb begin
    unique case (reg_addr_i)
      A_DEPTH: rd_val = REG_W'(DEPTH);
      A_WIDTH: rd_val = REG_W'(EW);
      A_STAT:  rd_val = REG_W'(stat);
      A_DATA:  rd_val = REG_W'(ram_rdata);
      A_RPTR:  rd_val = REG_W'(rptr_q);
      A_WPTR:  rd_val = REG_W'(wptr);
      A_TCNT:  rd_val = tcnt_q;
      default: rd_val = REG_W'(ctrl_q);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_val;
  end

  assign reg_rdata_o = rdata_q;
  assign status_o    = stat;

  // R10
  rptr_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !(reg_wr_i && reg_addr_i == A_RPTR)) |=> (rptr_q == $past(rptr_q) + 1'b1));

  // R12
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |=> $stable(reg_rdata_o));

  // R2
  idle_no_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[0] && empty) |-> !commit);
endmodule

// File: tb/trace_capture_buf_tb_top.sv
module trace_capture_buf_tb_top;
  import tcb_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tr_valid = 1'b0;
  logic [7:0]  tr_data = '0;
  logic        trig = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  status;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  logic        ended = 1'b0;

  always #2.5 clk = ~clk;

  trace_capture_buf dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tr_valid_i  (tr_valid),
    .tr_data_i   (tr_data),
    .trig_i      (trig),
    .reg_wr_i    (reg_wr),
    .reg_rd_i    (reg_rd),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .status_o    (status)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: read data due one edge after the strobe
  always @(posedge clk) rd_seen <= reg_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) chk(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic send(input logic [7:0] base, input int n, input int t1, input int t2);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tr_valid = 1'b1;
      tr_data  = base + 8'(i);
      trig     = (i == t1) || (i == t2);
    end
    @(negedge clk);
    tr_valid = 1'b0; trig = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!ended) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(32'(status), 32'h8, "R1 status_o");
    reg_read(A_STAT, 32'h8, "R1 status reg");
    reg_read(A_CTRL, 32'h0, "R1 ctrl");
    reg_read(A_WPTR, 32'h0, "R1 wptr");
    reg_read(A_RPTR, 32'h0, "R1 rptr");
    // R11
    reg_read(A_DEPTH, 32'd16, "R11 depth");
    reg_read(A_WIDTH, 32'd16, "R11 width");
    reg_write(A_DEPTH, 32'd99);
    reg_read(A_DEPTH, 32'd16, "R11 depth write ignored");
    // R2
    send(8'h01, 3, -1, -1);
    reg_read(A_WPTR, 32'h0, "R2 disabled no store");
    // R3 / R10
    reg_write(A_CTRL, 32'h1);
    send(8'h11, 1, -1, -1);
    send(8'h22, 1, -1, -1);
    send(8'h33, 1, -1, -1);
    reg_read(A_WPTR, 32'd3, "R3 wptr advance");
    reg_write(A_RPTR, 32'd0);
    reg_read(A_DATA, 32'h11, "R3/R10 entry0");
    reg_read(A_DATA, 32'h22, "R10 entry1");
    reg_read(A_DATA, 32'h33, "R10 entry2");
    reg_read(A_RPTR, 32'd3, "R10 rptr incremented");
    // R5 wrap
    reg_write(A_WPTR, 32'd0);
    send(8'h40, 20, -1, -1);
    reg_read(A_WPTR, 32'd4, "R5 wptr wrapped");
    reg_read(A_STAT, 32'h9, "R5 full set");
    reg_write(A_RPTR, 32'd4);
    reg_read(A_DATA, 32'h44, "R5 oldest at wptr");
    reg_read(A_DATA, 32'h45, "R5 next oldest");
    // R6 / R7 / R9
    reg_write(A_WPTR, 32'd0);
    reg_read(A_STAT, 32'h8, "R9 full cleared");
    reg_write(A_TCNT, 32'd3);
    send(8'h60, 10, 2, 4);
    reg_read(A_WPTR, 32'd6, "R6/R7 three entries after trigger");
    reg_read(A_STAT, 32'he, "R6 triggered and complete");
    reg_write(A_RPTR, 32'd5);
    reg_read(A_DATA, 32'h65, "R6 last stored");
    reg_read(A_DATA, 32'h46, "R6 no store after stop");
    reg_write(A_WPTR, 32'd9);
    reg_read(A_STAT, 32'h8, "R9 flags cleared");
    reg_read(A_WPTR, 32'd9, "R9 wptr loaded");
    // R6 zero count
    reg_write(A_WPTR, 32'd0);
    reg_write(A_TCNT, 32'd0);
    send(8'h70, 5, 1, -1);
    reg_read(A_WPTR, 32'd2, "R6 zero count stops at trigger");
    reg_write(A_RPTR, 32'd2);
    reg_read(A_DATA, 32'h62, "R6 zero count no extra store");
    // R6 trigger flag timing
    reg_write(A_WPTR, 32'd0);
    reg_write(A_TCNT, 32'd100);
    @(negedge clk);
    trig = 1'b1;
    chk(32'(status[1]), 32'h0, "R6 triggered not before edge");
    @(negedge clk);
    trig = 1'b0;
    chk(32'(status), 32'ha, "R6 triggered next cycle");
    // R4 / R8 paired mode
    reg_write(A_WPTR, 32'd0);
    reg_write(A_CTRL, 32'h3);
    send(8'ha0, 3, -1, -1);
    chk(32'(status), 32'h0, "R4 half pending");
    reg_write(A_CTRL, 32'h2);
    @(negedge clk);
    chk(32'(status), 32'h8, "R8 flushed empty");
    reg_read(A_WPTR, 32'd2, "R8 flush stored");
    reg_write(A_RPTR, 32'd0);
    reg_read(A_DATA, 32'ha1a0, "R4 packed pair");
    reg_read(A_DATA, 32'h00a2, "R8 flushed half");
    // R12 hold
    repeat (3) @(negedge clk);
    chk(reg_rdata, 32'h00a2, "R12 rdata holds");
    repeat (3) @(negedge clk);
    ended = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule